// File: doc/BRIEF.md
# Bit-Serial Predicated SIMD Cell

This block is one processing cell of a wide single-instruction array. Every cell in the array receives the same microinstruction on a shared bus and runs it against its own state: a 4096-deep, one-bit-wide data store and sixteen one-bit flags. Each microinstruction fetches two data bits and one flag, and computes two results by looking them up in two 8-entry truth tables carried in the instruction itself. It writes one result into the data store and the other into a flag. There is no opcode: the tables are the operation.

Execution can be switched off per cell. The instruction names one flag and a sense bit. A cell whose named flag differs from the sense bit treats the instruction as a no-op, so a broadcast stream can act on a data-dependent subset of the array. The flag result is also driven out towards a neighbour, together with a two-bit direction code. Flag 0 is not storage: it always reads the bit arriving from a neighbour, which lets that bit take part in the next computation. A simple load port fills the data store while the cell is idle.

Top module: `bsp_cell`

## Requirements
- R1: After reset `done`, `nbr_out` and `nbr_dir` are 0 and flags 1 to 15 read as 0. The data store is not cleared.
- R2: `ins_word` holds these fields from bit 54 down to bit 0: A address [54:43], B address [42:31], read-flag select [30:27], write-flag select [26:23], condition-flag select [22:19], sense [18], memory table [17:10], flag table [9:2], direction [1:0].
- R3: The operand index is 4*a + 2*b + f, where a is the store bit at A, b is the store bit at B and f is the flag picked by the read-flag select. The memory result is bit [index] of the memory table and the flag result is bit [index] of the flag table.
- R4: The instruction executes only if the flag picked by the condition-flag select equals the sense bit. Otherwise it changes no store bit, no flag, `nbr_out` and `nbr_dir`, and `done` still pulses.
- R5: An executed instruction writes the memory result to address A and the flag result to the write-flag select. It sets `nbr_out` to the flag result and `nbr_dir` to the direction field (0 north, 1 east, 2 west, 3 south). Both outputs hold until the next executed instruction.
- R6: `start` is accepted at a rising edge while the cell is idle. `done` is high for exactly the one cycle after the third rising edge following acceptance, and a new `start` may be accepted at the next edge.
- R7: `start` and `ins_word` are ignored while an instruction is in progress. A held `start` causes no second execution.
- R8: Flag 0 reads `nbr_in`, sampled at the second edge after acceptance, both as an operand and as a condition. Writes that select flag 0 are discarded.
- R9: `load_en` writes `load_data` to `load_addr` at a rising edge only when the cell is idle and `start` is low. Otherwise the load is ignored.
- R10: Both operands and the flag are read before any write, so A equal to B reads one cell twice, and a read-flag equal to the write-flag sees the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to run the instruction on `ins_word` |
| ins_word | input | 55 | Broadcast microinstruction |
| done | output | 1 | One-cycle completion pulse |
| nbr_in | input | 1 | Bit from a neighbour, read as flag 0 |
| nbr_out | output | 1 | Last executed flag result, sent to a neighbour |
| nbr_dir | output | 2 | Destination neighbour of `nbr_out` |
| load_en | input | 1 | Store load strobe |
| load_addr | input | 12 | Store load address |
| load_data | input | 1 | Store load bit |

## Verification
The assertions assume that `rst_n` is low before the first edge, because the phase register and the flags start from reset. The bench asserts reset for several cycles before any other stimulus. The data store has no reset, so a read of a cell that was never written yields an unknown operand. The stimulus therefore loads every address that an instruction or probe will touch. `nbr_in` is sampled at one edge inside the instruction, so the bench sets it with `start` and holds it until `done`.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int ADDR_W = 12;
  localparam int FSEL_W = 4;
  localparam int NFLAG  = 1 << FSEL_W;
  localparam int TAB_W  = 8;
  localparam int DIR_W  = 2;
  localparam int INS_W  = 2*ADDR_W + 3*FSEL_W + 1 + 2*TAB_W + DIR_W;

  // Field order (msb first) is the broadcast bus contract.
  typedef struct packed {
    logic [ADDR_W-1:0] a_addr;
    logic [ADDR_W-1:0] b_addr;
    logic [FSEL_W-1:0] rd_f;
    logic [FSEL_W-1:0] wr_f;
    logic [FSEL_W-1:0] cnd_f;
    logic              sense;
    logic [TAB_W-1:0]  mem_tab;
    logic [TAB_W-1:0]  flg_tab;
    logic [DIR_W-1:0]  dir;
  } pe_ins_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RDA  = 2'd1,
    PH_RDB  = 2'd2,
    PH_EXE  = 2'd3
  } pe_phase_e;

  // Three-input lookup: operand a is the most significant index bit.
  function automatic logic lut3(input logic [TAB_W-1:0] tab,
                                input logic a, input logic b, input logic f);
    return tab[{a, b, f}];
  endfunction

endpackage

// File: rtl/bsp_seq.sv
module bsp_seq
  import bsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic idle_ph,
  output logic rda_ph,
  output logic rdb_ph,
  output logic exe_ph,
  output logic done
);

  pe_phase_e ph_q, ph_d;
  logic      done_q;

  assign idle_ph = (ph_q == PH_IDLE);
  assign rda_ph  = (ph_q == PH_RDA);
  assign rdb_ph  = (ph_q == PH_RDB);
  assign exe_ph  = (ph_q == PH_EXE);
  assign accept  = start && idle_ph;
  assign done    = done_q;

  always_comb begin
    ph_d = ph_q;
    case (ph_q)
      PH_IDLE: if (start) ph_d = PH_RDA;
      PH_RDA:  ph_d = PH_RDB;
      PH_RDB:  ph_d = PH_EXE;
      PH_EXE:  ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      done_q <= exe_ph;
    end
  end

  // R6: the execute step comes exactly three edges after acceptance
  p_accept_to_exe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exe_ph |-> $past(accept, 3));

  // R6: done follows the execute step
  p_done_follows_exe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(exe_ph));

  // R6: done lasts a single cycle
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/bsp_bitmem.sv
module bsp_bitmem #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit
);

  localparam int DEPTH = 1 << AW;

  logic cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wr_addr] <= wr_bit;
  end

  assign rd_bit = cells[rd_addr];

endmodule

// File: rtl/bsp_flagbank.sv
module bsp_flagbank #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_bit,
  input  logic [SW-1:0] rd_sel,
  input  logic [SW-1:0] cnd_sel,
  output logic          rd_bit,
  output logic          cnd_bit,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic          wr_bit
);

  localparam int N = 1 << SW;

  logic [N-1:1] fq;
  logic [N-1:0] view;

  // Slot 0 has no storage; the external bit stands in for it.
  for (genvar i = 1; i < N; i++) begin : g_flag
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cell_q <= 1'b0;
      else if (wr_en && (wr_sel == SW'(i)))    cell_q <= wr_bit;
    end
    assign fq[i] = cell_q;
  end

  assign view    = {fq, ext_bit};
  assign rd_bit  = view[rd_sel];
  assign cnd_bit = view[cnd_sel];

  // R4: flags change only on a write
  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(fq));

  // R8: a write aimed at slot 0 leaves every stored flag alone
  p_flag0_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0) |=> $stable(fq));

endmodule

// File: rtl/bsp_cell.sv
module bsp_cell
  import bsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [INS_W-1:0]  ins_word,
  output logic              done,
  input  logic              nbr_in,
  output logic              nbr_out,
  output logic [DIR_W-1:0]  nbr_dir,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              load_data
);

  logic accept, idle_ph, rda_ph, rdb_ph, exe_ph;

  bsp_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .accept  (accept),
    .idle_ph (idle_ph),
    .rda_ph  (rda_ph),
    .rdb_ph  (rdb_ph),
    .exe_ph  (exe_ph),
    .done    (done)
  );

  pe_ins_t ins_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ins_q <= '0;
    else if (accept) ins_q <= pe_ins_t'(ins_word);
  end

  // One store read port, steered by phase: A first, then B.
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_bit;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic              mem_wbit;

  assign rd_addr = rda_ph ? ins_q.a_addr : ins_q.b_addr;

  bsp_bitmem #(.AW(ADDR_W)) u_mem (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_bit  (rd_bit),
    .we      (mem_we),
    .wr_addr (mem_waddr),
    .wr_bit  (mem_wbit)
  );

  logic flg_rd, flg_cnd;
  logic commit;
  logic res_mem, res_flg;

  bsp_flagbank #(.SW(FSEL_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_bit (nbr_in),
    .rd_sel  (ins_q.rd_f),
    .cnd_sel (ins_q.cnd_f),
    .rd_bit  (flg_rd),
    .cnd_bit (flg_cnd),
    .wr_en   (commit),
    .wr_sel  (ins_q.wr_f),
    .wr_bit  (res_flg)
  );

  // Operand capture.
  logic opa_q, opb_q, opf_q, cnd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opa_q <= 1'b0;
      opb_q <= 1'b0;
      opf_q <= 1'b0;
      cnd_q <= 1'b0;
    end else begin
      if (rda_ph) opa_q <= rd_bit;
      if (rdb_ph) begin
        opb_q <= rd_bit;
        opf_q <= flg_rd;
        cnd_q <= flg_cnd;
      end
    end
  end

  logic cond_hit;
  logic ld_take;

  assign cond_hit = (cnd_q == ins_q.sense);
  assign commit   = exe_ph && cond_hit;
  assign res_mem  = lut3(ins_q.mem_tab, opa_q, opb_q, opf_q);
  assign res_flg  = lut3(ins_q.flg_tab, opa_q, opb_q, opf_q);

  assign ld_take   = load_en && idle_ph && !start;
  assign mem_we    = commit || ld_take;
  assign mem_waddr = commit ? ins_q.a_addr : load_addr;
  assign mem_wbit  = commit ? res_mem : load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbr_out <= 1'b0;
      nbr_dir <= '0;
    end else if (commit) begin
      nbr_out <= res_flg;
      nbr_dir <= ins_q.dir;
    end
  end

  // R4: neighbour outputs move only on an executed instruction
  p_nbr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(nbr_out) && $stable(nbr_dir)));

  // R4: a commit directly follows the second read step
  p_commit_after_rdb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(rdb_ph));

  // R7: the latched instruction stays put while busy
  p_ins_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_ph && $past(!idle_ph)) |-> $stable(ins_q));

endmodule

// File: tb/sim_bsp_cell.sv
`timescale 1ns/1ps
module sim_bsp_cell;
  import bsp_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [INS_W-1:0]  ins_word = '0;
  logic              done;
  logic              nbr_in = 1'b0;
  logic              nbr_out;
  logic [DIR_W-1:0]  nbr_dir;
  logic              load_en = 1'b0;
  logic [ADDR_W-1:0] load_addr = '0;
  logic              load_data = 1'b0;

  int n_vec = 0;
  int n_bad = 0;

  bit       m_mem [4096];
  bit       m_flag [16];
  bit       e_out = 1'b0;
  bit [1:0] e_dir = 2'd0;

  always #2 clk = ~clk;

  bsp_cell u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .ins_word  (ins_word),
    .done      (done),
    .nbr_in    (nbr_in),
    .nbr_out   (nbr_out),
    .nbr_dir   (nbr_dir),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Reference: predict the effect of one instruction on the model state.
  task automatic model_ins(input logic [11:0] a, input logic [11:0] b,
                           input logic [3:0] rf, input logic [3:0] wf, input logic [3:0] cf,
                           input logic s, input logic [7:0] mt, input logic [7:0] ft,
                           input logic [1:0] nw, input logic nin);
    bit va, vb, vf, vc;
    int idx;
    va  = m_mem[a];
    vb  = m_mem[b];
    vf  = (rf == 4'd0) ? nin : m_flag[rf];
    vc  = (cf == 4'd0) ? nin : m_flag[cf];
    idx = (va ? 4 : 0) + (vb ? 2 : 0) + (vf ? 1 : 0);
    if (vc == s) begin
      m_mem[a] = mt[idx];
      if (wf != 4'd0) m_flag[wf] = ft[idx];
      e_out = ft[idx];
      e_dir = nw;
    end
  endtask

  task automatic run_ins(input string tag, input logic [11:0] a, input logic [11:0] b,
                         input logic [3:0] rf, input logic [3:0] wf, input logic [3:0] cf,
                         input logic s, input logic [7:0] mt, input logic [7:0] ft,
                         input logic [1:0] nw, input logic nin);
    model_ins(a, b, rf, wf, cf, s, mt, ft, nw, nin);
    @(negedge clk);
    nbr_in   = nin;
    ins_word = {a, b, rf, wf, cf, s, mt, ft, nw};
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R6 done low step1"}, done, 0);
    @(negedge clk);
    chk({tag, " R6 done low step2"}, done, 0);
    @(negedge clk);
    chk({tag, " R6 done low step3"}, done, 0);
    @(negedge clk);
    chk({tag, " R6 done pulse"}, done, 1);
    chk({tag, " R5 nbr_out"}, nbr_out, e_out);
    chk({tag, " R5 nbr_dir"}, nbr_dir, e_dir);
  endtask

  task automatic ld(input logic [11:0] addr, input logic bv);
    @(negedge clk);
    load_en = 1'b1; load_addr = addr; load_data = bv;
    @(negedge clk);
    load_en = 1'b0;
    m_mem[addr] = bv;
  endtask

  // Table F0 copies operand a; AA copies operand f.
  task automatic probe_mem(input string tag, input logic [11:0] addr);
    run_ins({tag, " mem probe"}, addr, addr, 4'd0, 4'd0, 4'd0, 1'b0, 8'hF0, 8'hF0, 2'd0, 1'b0);
  endtask

  task automatic probe_flag(input string tag, input logic [3:0] f);
    run_ins({tag, " flag probe"}, 12'd0, 12'd0, f, 4'd0, 4'd0, 1'b0, 8'hF0, 8'hAA, 2'd0, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 done after reset", done, 0);
    chk("R1 nbr_out after reset", nbr_out, 0);
    chk("R1 nbr_dir after reset", nbr_dir, 0);
  endtask

  task automatic t_load();
    for (int i = 0; i < 8; i++) ld(12'(i), (i == 1) || (i == 2) || (i == 4) || (i == 6));
    ld(12'd4095, 1'b1);
    ld(12'd2048, 1'b0);
    ld(12'd2047, 1'b1);
    for (int i = 0; i < 8; i++) probe_mem("R9 load", 12'(i));
    probe_mem("R2 top address", 12'd4095);
    probe_mem("R2 mid address", 12'd2048);
    probe_mem("R2 below mid", 12'd2047);
  endtask

  task automatic t_flag_reset();
    probe_flag("R1 flag1", 4'd1);
    probe_flag("R1 flag8", 4'd8);
    probe_flag("R1 flag15", 4'd15);
  endtask

  // R3 sweep of all operand combinations, xor3 and majority tables.
  task automatic t_sweep();
    for (int k = 0; k < 8; k++) begin
      ld(12'(100 + k), k[2]);
      run_ins("R3 sweep", 12'(100 + k), k[1] ? 12'd1 : 12'd0, 4'd0, 4'd9, 4'd0,
              k[0], 8'h96, 8'hE8, 2'(k), k[0]);
      probe_mem("R3 R5 result at A", 12'(100 + k));
      probe_flag("R3 R5 flag result", 4'd9);
    end
  endtask

  task automatic t_predicate();
    run_ins("R4 set flag5", 12'd0, 12'd0, 4'd0, 4'd5, 4'd0, 1'b0, 8'hF0, 8'hFF, 2'd1, 1'b0);
    run_ins("R4 noop", 12'd1, 12'd1, 4'd0, 4'd6, 4'd5, 1'b0, 8'h00, 8'hFF, 2'd2, 1'b0);
    probe_mem("R4 store kept", 12'd1);
    probe_flag("R4 flag kept", 4'd6);
    run_ins("R4 taken", 12'd2, 12'd2, 4'd0, 4'd6, 4'd5, 1'b1, 8'h00, 8'hFF, 2'd3, 1'b0);
    probe_mem("R4 store written", 12'd2);
    probe_flag("R4 flag written", 4'd6);
  endtask

  task automatic t_flag0();
    run_ins("R8 write flag0", 12'd0, 12'd0, 4'd0, 4'd0, 4'd0, 1'b0, 8'hF0, 8'hFF, 2'd0, 1'b0);
    probe_flag("R8 flag0 stays nbr_in", 4'd0);
    probe_flag("R8 flag15 untouched", 4'd15);
    run_ins("R8 nbr_in high", 12'd0, 12'd0, 4'd0, 4'd0, 4'd0, 1'b1, 8'hF0, 8'hAA, 2'd1, 1'b1);
    run_ins("R8 cond on nbr_in", 12'd4, 12'd4, 4'd0, 4'd7, 4'd0, 1'b1, 8'h00, 8'hFF, 2'd2, 1'b0);
    probe_mem("R8 skipped store", 12'd4);
  endtask

  task automatic t_same_cell();
    ld(12'd200, 1'b1);
    run_ins("R10 A=B first", 12'd200, 12'd200, 4'd8, 4'd8, 4'd0, 1'b0, 8'h40, 8'h55, 2'd0, 1'b0);
    run_ins("R10 A=B second", 12'd200, 12'd200, 4'd8, 4'd8, 4'd0, 1'b0, 8'h40, 8'h55, 2'd3, 1'b0);
    probe_mem("R10 store", 12'd200);
    probe_flag("R10 flag", 4'd8);
  endtask

  // R7 held start, R9 loads overlapping start and busy phases.
  task automatic t_busy();
    bit old5, old6;
    old5 = m_mem[5];
    old6 = m_mem[6];
    model_ins(12'd3, 12'd4, 4'd0, 4'd10, 4'd0, 1'b0, 8'hFF, 8'hFF, 2'd1, 1'b0);
    @(negedge clk);
    nbr_in = 1'b0;
    ins_word = {12'd3, 12'd4, 4'd0, 4'd10, 4'd0, 1'b0, 8'hFF, 8'hFF, 2'd1};
    start = 1'b1;
    load_en = 1'b1; load_addr = 12'd5; load_data = ~old5;
    @(negedge clk);
    load_addr = 12'd6; load_data = ~old6;
    ins_word = {12'd5, 12'd5, 4'd0, 4'd11, 4'd0, 1'b0, 8'h00, 8'hFF, 2'd2};
    @(negedge clk);
    load_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R7 first done", done, 1);
    chk("R7 nbr_out", nbr_out, e_out);
    chk("R7 nbr_dir", nbr_dir, e_dir);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R7 no second done", done, 0);
    end
    probe_mem("R9 load with start", 12'd5);
    probe_mem("R9 load while busy", 12'd6);
    probe_mem("R7 A written", 12'd3);
    probe_flag("R7 flag10", 4'd10);
    probe_flag("R7 flag11 untouched", 4'd11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_flag_reset();
    t_sweep();
    t_predicate();
    t_flag0();
    t_same_cell();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule